// File: doc/BRIEF.md
# Coalescing Interrupt Status Controller

This block gathers interrupt causes from a receive DMA engine, a transmit DMA engine and a handful of miscellaneous sources. It holds them in two status words that the host reads and acknowledges by writing ones. The detailed word records each DMA cause in its own bit. The main word carries the miscellaneous causes directly and a one-bit summary of each group of DMA causes. A host-written enable mask selects which main-word bits may interrupt.

The interrupt line is not raised at once. A coalescing timer, programmed in units of 32 microsecond ticks, lets causes gather first. An urgent receive cause, or a coalescing value of zero, raises the line without waiting. Once raised, the line stays high until the host has acknowledged every enabled cause.

A three-state machine drives the line. IDLE means no enabled cause is present. WAIT means the coalescing window is running. FIRE means the line is asserted. The transitions are:
- IDLE to FIRE when an enabled cause appears and it is urgent or the interval is zero.
- IDLE to WAIT when any other enabled cause appears.
- WAIT to FIRE when the last tick of the window arrives, an urgent cause appears, or the interval is set to zero.
- WAIT to IDLE when the host clears every enabled cause first.
- FIRE to IDLE when no enabled cause remains.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset, all four registers read 0 and `host_irq` is low.
- R2: A status bit is set by its event pulse and stays set until the host writes 1 to it. Writing 0 to a bit leaves it unchanged.
- R3: If an event pulse and a write-1 acknowledge hit the same status bit in the same cycle, the bit ends up set.
- R4: The detailed word (address 1) holds transmit channels 0/1 at bits 0/1, receive channels 0/1 at bits 16/17, the urgent receive cause at bit 30 and the DMA error at bit 31. Main-word bit 31 reads 1 whenever detailed bit 16, 17 or 30 is set.
- R5: Main-word bit 27 reads 1 when detailed bit 0 or 1 is set, and main-word bit 29 mirrors detailed bit 31. Writing 1 to these three summary bits in the main word has no effect; they clear only through the detailed word.
- R6: `misc_ev[0]` sets main bit 0 (firmware alive), `misc_ev[1]` sets bit 1 (wake-up), `misc_ev[2]` sets bit 6 (over-temperature), `misc_ev[3]` sets bit 7 (radio kill switch) and `misc_ev[4]` sets bit 25 (firmware error).
- R7: The mask (address 2) reads back all 32 written bits. The coalescing register (address 3) reads back its low COAL_W bits, upper bits 0. Status bits with no source always read 0. The main word is at address 0.
- R8: `host_irq` is low in every cycle that follows a cycle with no cause enabled by the mask.
- R9: With a nonzero coalescing value N, `host_irq` rises on the clock edge that samples the 32*N-th `us_tick` counted from the IDLE-to-WAIT move. Cycles without a tick do not advance the window.
- R10: With a coalescing value of 0, `host_irq` rises one cycle after the enabled status bit becomes visible.
- R11: An urgent receive cause with mask bit 31 set raises `host_irq` one cycle after it becomes visible, whatever the coalescing value.
- R12: `host_irq` stays high while any enabled cause remains and falls one cycle after the last one is cleared. Clearing all causes during WAIT returns to IDLE without an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 main, 1 detailed, 2 mask, 3 coalescing |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data (write-1-to-clear for the status words) |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| rx_chan_ev | input | 2 | Receive channel 1/0 completion pulses |
| tx_chan_ev | input | 2 | Transmit channel 1/0 completion pulses |
| dma_err_ev | input | 1 | DMA error pulse |
| rx_urgent_ev | input | 1 | Urgent receive pulse that bypasses coalescing |
| misc_ev | input | 5 | Miscellaneous cause pulses, mapped as in R6 |
| us_tick | input | 1 | One pulse per microsecond |
| host_irq | output | 1 | Interrupt to the host |

## Verification
The assertions check every cycle that acknowledged bits only drop on a write of one and that a same-cycle event always wins. They also check the line behaviour: low after any cycle without an enabled cause, never firing from WAIT without a tick or urgent cause, immediate when the interval is zero or the cause is urgent, and held while causes remain. Only the bench scenarios can show the bit positions of each source, the summary folding, register readback widths, and the exact tick count at which the coalescing window expires.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIRE = 2'd2
    } coal_state_e;

    // register select values
    localparam logic [1:0] SEL_MAIN = 2'd0;
    localparam logic [1:0] SEL_FLOW = 2'd1;
    localparam logic [1:0] SEL_MASK = 2'd2;
    localparam logic [1:0] SEL_COAL = 2'd3;

    // main word summary positions
    localparam int MB_RX_SUM  = 31;
    localparam int MB_DMA_ERR = 29;
    localparam int MB_TX_SUM  = 27;

    // miscellaneous sources: index i of misc_ev lands at MISC_POS[i]
    localparam int NUM_MISC = 5;
    localparam int MISC_POS [NUM_MISC] = '{0, 1, 6, 7, 25};

    // detailed word: index i of the flow vector lands at FLOW_POS[i]
    // order of the flow vector: tx0, tx1, rx0, rx1, urgent, error
    localparam int NUM_FLOW = 6;
    localparam int FLOW_POS [NUM_FLOW] = '{0, 1, 16, 17, 30, 31};
    localparam int FI_TX0 = 0;
    localparam int FI_TX1 = 1;
    localparam int FI_RX0 = 2;
    localparam int FI_RX1 = 3;
    localparam int FI_URG = 4;
    localparam int FI_ERR = 5;

endpackage

// File: rtl/irqc_w1c_bits.sv
module irqc_w1c_bits #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] bits_o
);

    logic [N-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= (bits_q & ~clr_i) | set_i;
        end
    end

    assign bits_o = bits_q;

    // R2: a bit that was set falls only when a one was written to it
    a_r2_clear_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(bits_q) & ~$past(clr_i))) & ~bits_q) == '0));

    // R3: every pulsed bit is set afterwards, even with a clear in the same cycle
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(set_i) & ~bits_q) == '0));

endmodule

// File: rtl/irqc_status_regs.sv
module irqc_status_regs
    import irqc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_FLOW-1:0] flow_set,
    input  logic [NUM_FLOW-1:0] flow_clr,
    input  logic [NUM_MISC-1:0] misc_set,
    input  logic [NUM_MISC-1:0] misc_clr,
    output logic [DW-1:0]       main_word,
    output logic [DW-1:0]       flow_word
);

    logic [NUM_FLOW-1:0] flow_bits;
    logic [NUM_MISC-1:0] misc_bits;

    irqc_w1c_bits #(.N(NUM_FLOW)) u_flow (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flow_set),
        .clr_i  (flow_clr),
        .bits_o (flow_bits)
    );

    irqc_w1c_bits #(.N(NUM_MISC)) u_misc (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (misc_set),
        .clr_i  (misc_clr),
        .bits_o (misc_bits)
    );

    always_comb begin
        flow_word = '0;
        for (int i = 0; i < NUM_FLOW; i++) begin
            flow_word[FLOW_POS[i]] = flow_bits[i];
        end
    end

    always_comb begin
        main_word = '0;
        for (int i = 0; i < NUM_MISC; i++) begin
            main_word[MISC_POS[i]] = misc_bits[i];
        end
        main_word[MB_RX_SUM]  = flow_bits[FI_RX0] | flow_bits[FI_RX1] | flow_bits[FI_URG];
        main_word[MB_TX_SUM]  = flow_bits[FI_TX0] | flow_bits[FI_TX1];
        main_word[MB_DMA_ERR] = flow_bits[FI_ERR];
    end

endmodule

// File: rtl/irqc_coal_fsm.sv
module irqc_coal_fsm
    import irqc_pkg::*;
#(
    parameter int unsigned COAL_W         = 8,
    parameter int unsigned TICKS_PER_UNIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cause_any,
    input  logic              urgent_any,
    input  logic [COAL_W-1:0] coal_val,
    input  logic              us_tick,
    output logic              irq_o
);

    localparam int unsigned CW = COAL_W + $clog2(TICKS_PER_UNIT);

    coal_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          cnt_last;
    logic          coal_zero;

    assign limit     = CW'(coal_val) * CW'(TICKS_PER_UNIT);
    assign cnt_last  = (cnt_q == (limit - CW'(1)));
    assign coal_zero = (coal_val == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cause_any) begin
                    state_d = (urgent_any || coal_zero) ? ST_FIRE : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!cause_any) begin
                    state_d = ST_IDLE;
                end else if (urgent_any || coal_zero || (us_tick && cnt_last)) begin
                    state_d = ST_FIRE;
                end
            end
            ST_FIRE: begin
                if (!cause_any) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // window counter, runs on ticks only while waiting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q != ST_WAIT) begin
            cnt_q <= '0;
        end else if (us_tick) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // outputs
    always_comb begin
        irq_o = (state_q == ST_FIRE);
    end

    // R8: no enabled cause means the line is low next cycle
    a_r8_no_irq_without_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_any |=> !irq_o);

    // R9: the window only expires on a tick
    a_r9_wait_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) && cause_any && !urgent_any && !coal_zero && !us_tick |=> !irq_o);

    // R10: zero interval fires straight from idle
    a_r10_zero_interval: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && cause_any && coal_zero |=> irq_o);

    // R11: urgent cause bypasses the window
    a_r11_urgent_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        cause_any && urgent_any |=> irq_o);

    // R12: line held while causes remain
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && cause_any |=> irq_o);

endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned COAL_W         = 8,
    parameter int unsigned TICKS_PER_UNIT = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    input  logic [1:0]          rx_chan_ev,
    input  logic [1:0]          tx_chan_ev,
    input  logic                dma_err_ev,
    input  logic                rx_urgent_ev,
    input  logic [NUM_MISC-1:0] misc_ev,
    input  logic                us_tick,
    output logic                host_irq
);

    logic                wr_main, wr_flow, wr_mask, wr_coal;
    logic [NUM_FLOW-1:0] flow_set, flow_clr;
    logic [NUM_MISC-1:0] misc_clr;
    logic [DW-1:0]       main_word, flow_word;
    logic [DW-1:0]       mask_q;
    logic [COAL_W-1:0]   coal_q;
    logic                cause_any, urgent_any;

    assign wr_main = reg_wr && (reg_addr == SEL_MAIN);
    assign wr_flow = reg_wr && (reg_addr == SEL_FLOW);
    assign wr_mask = reg_wr && (reg_addr == SEL_MASK);
    assign wr_coal = reg_wr && (reg_addr == SEL_COAL);

    // event vector in flow order: tx0, tx1, rx0, rx1, urgent, error
    assign flow_set = {dma_err_ev, rx_urgent_ev, rx_chan_ev, tx_chan_ev};

    for (genvar i = 0; i < NUM_FLOW; i++) begin : g_flow_clr
        assign flow_clr[i] = wr_flow & reg_wdata[FLOW_POS[i]];
    end

    for (genvar i = 0; i < NUM_MISC; i++) begin : g_misc_clr
        assign misc_clr[i] = wr_main & reg_wdata[MISC_POS[i]];
    end

    irqc_status_regs u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_set  (flow_set),
        .flow_clr  (flow_clr),
        .misc_set  (misc_ev),
        .misc_clr  (misc_clr),
        .main_word (main_word),
        .flow_word (flow_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            coal_q <= '0;
        end else begin
            if (wr_mask) mask_q <= reg_wdata;
            if (wr_coal) coal_q <= reg_wdata[COAL_W-1:0];
        end
    end

    always_comb begin
        unique case (reg_addr)
            SEL_MAIN: reg_rdata = main_word;
            SEL_FLOW: reg_rdata = flow_word;
            SEL_MASK: reg_rdata = mask_q;
            default:  reg_rdata = DW'(coal_q);
        endcase
    end

    assign cause_any  = |(main_word & mask_q);
    assign urgent_any = flow_word[FLOW_POS[FI_URG]] & mask_q[MB_RX_SUM];

    irqc_coal_fsm #(
        .COAL_W         (COAL_W),
        .TICKS_PER_UNIT (TICKS_PER_UNIT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cause_any  (cause_any),
        .urgent_any (urgent_any),
        .coal_val   (coal_q),
        .us_tick    (us_tick),
        .irq_o      (host_irq)
    );

endmodule

// File: tb/tb_irq_coalesce_ctrl.sv
`timescale 1ns/1ps
module tb_irq_coalesce_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [1:0]  rx_chan_ev;
    logic [1:0]  tx_chan_ev;
    logic        dma_err_ev;
    logic        rx_urgent_ev;
    logic [4:0]  misc_ev;
    logic        us_tick;
    logic        host_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_coalesce_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .rx_chan_ev   (rx_chan_ev),
        .tx_chan_ev   (tx_chan_ev),
        .dma_err_ev   (dma_err_ev),
        .rx_urgent_ev (rx_urgent_ev),
        .misc_ev      (misc_ev),
        .us_tick      (us_tick),
        .host_irq     (host_irq)
    );

    // {rx[1:0], tx[1:0], err, urgent, misc[4:0], expected main, expected detailed}
    localparam int NV = 9;
    localparam logic [74:0] VEC [NV] = '{
        {2'b01, 2'b00, 1'b0, 1'b0, 5'b00000, 32'h8000_0000, 32'h0001_0000},
        {2'b10, 2'b00, 1'b0, 1'b0, 5'b00000, 32'h8000_0000, 32'h0002_0000},
        {2'b00, 2'b01, 1'b0, 1'b0, 5'b00000, 32'h0800_0000, 32'h0000_0001},
        {2'b00, 2'b11, 1'b0, 1'b0, 5'b00000, 32'h0800_0000, 32'h0000_0003},
        {2'b00, 2'b00, 1'b1, 1'b0, 5'b00000, 32'h2000_0000, 32'h8000_0000},
        {2'b00, 2'b00, 1'b0, 1'b1, 5'b00000, 32'h8000_0000, 32'h4000_0000},
        {2'b00, 2'b00, 1'b0, 1'b0, 5'b10001, 32'h0200_0001, 32'h0000_0000},
        {2'b00, 2'b00, 1'b0, 1'b0, 5'b01110, 32'h0000_00C2, 32'h0000_0000},
        {2'b11, 2'b11, 1'b1, 1'b1, 5'b11111, 32'hAA00_00C3, 32'hC003_0003}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic pulse(input logic [1:0] rx, input logic [1:0] tx, input logic err,
                         input logic urg, input logic [4:0] misc);
        @(negedge clk);
        rx_chan_ev = rx; tx_chan_ev = tx; dma_err_ev = err; rx_urgent_ev = urg; misc_ev = misc;
        @(negedge clk);
        rx_chan_ev = '0; tx_chan_ev = '0; dma_err_ev = 1'b0; rx_urgent_ev = 1'b0; misc_ev = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        us_tick = 1'b1;
        @(negedge clk);
        us_tick = 1'b0;
    endtask

    task automatic clear_all();
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'hFFFF_FFFF);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        rx_chan_ev = '0; tx_chan_ev = '0; dma_err_ev = 1'b0; rx_urgent_ev = 1'b0;
        misc_ev = '0; us_tick = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 reset irq", {31'h0, host_irq}, 32'h0);

        // R4 R5 R6 source mapping table, mask zero
        for (int v = 0; v < NV; v++) begin
            pulse(VEC[v][74:73], VEC[v][72:71], VEC[v][70], VEC[v][69], VEC[v][68:64]);
            rd(2'd0, d);
            check("R4 R5 R6 main word", d, VEC[v][63:32]);
            rd(2'd1, d);
            check("R4 R5 R6 detailed word", d, VEC[v][31:0]);
            check("R8 masked causes keep irq low", {31'h0, host_irq}, 32'h0);
            clear_all();
            rd(2'd0, d);
            check("R2 cleared main", d, 32'h0);
            rd(2'd1, d);
            check("R2 cleared detailed", d, 32'h0);
        end

        // R2 writing zero or to other bits leaves a set bit alone
        pulse(2'b00, 2'b00, 1'b0, 1'b0, 5'b00001);
        wr(2'd0, 32'h0000_0000);
        rd(2'd0, d);
        check("R2 write zero keeps bit", d, 32'h0000_0001);
        wr(2'd0, 32'h0000_0002);
        rd(2'd0, d);
        check("R2 write other bit keeps bit", d, 32'h0000_0001);
        wr(2'd0, 32'h0000_0001);
        rd(2'd0, d);
        check("R2 write one clears", d, 32'h0);

        // R3 set wins over simultaneous clear
        pulse(2'b00, 2'b00, 1'b0, 1'b0, 5'b00001);
        @(negedge clk);
        misc_ev = 5'b00001; reg_addr = 2'd0; reg_wdata = 32'h1; reg_wr = 1'b1;
        @(negedge clk);
        misc_ev = '0; reg_wr = 1'b0;
        rd(2'd0, d);
        check("R3 set wins", d, 32'h0000_0001);
        clear_all();

        // R5 summary bits not writable in main word
        pulse(2'b00, 2'b01, 1'b0, 1'b0, 5'b00000);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d);
        check("R5 summary survives main write", d, 32'h0800_0000);
        wr(2'd1, 32'h0000_0001);
        rd(2'd0, d);
        check("R5 summary clears via detailed", d, 32'h0);

        // R7 readback widths
        wr(2'd2, 32'hA5C3_0F01);
        rd(2'd2, d);
        check("R7 mask readback", d, 32'hA5C3_0F01);
        wr(2'd3, 32'h0000_01FF);
        rd(2'd3, d);
        check("R7 coal truncated", d, 32'h0000_00FF);
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h0);

        // R8 masked cause, then enable it
        pulse(2'b00, 2'b00, 1'b0, 1'b0, 5'b11111);
        repeat (3) @(negedge clk);
        check("R8 masked no irq", {31'h0, host_irq}, 32'h0);
        wr(2'd2, 32'h0000_0001);
        @(negedge clk);
        check("R10 unmask fires", {31'h0, host_irq}, 32'h1);
        clear_all();
        check("R12 irq low after clear", {31'h0, host_irq}, 32'h0);

        // R10 zero interval
        pulse(2'b00, 2'b00, 1'b0, 1'b0, 5'b00001);
        check("R10 not before fsm edge", {31'h0, host_irq}, 32'h0);
        @(negedge clk);
        check("R10 immediate irq", {31'h0, host_irq}, 32'h1);
        repeat (5) @(negedge clk);
        check("R12 irq held", {31'h0, host_irq}, 32'h1);
        wr(2'd0, 32'h0000_0001);
        check("R12 still high at clear edge", {31'h0, host_irq}, 32'h1);
        @(negedge clk);
        check("R12 falls after clear", {31'h0, host_irq}, 32'h0);

        // R9 coalescing window of one unit
        wr(2'd3, 32'h1);
        pulse(2'b00, 2'b00, 1'b0, 1'b0, 5'b00001);
        @(negedge clk);
        repeat (20) @(negedge clk);
        check("R9 no ticks no irq", {31'h0, host_irq}, 32'h0);
        for (int k = 0; k < 31; k++) tick();
        check("R9 low after 31 ticks", {31'h0, host_irq}, 32'h0);
        tick();
        check("R9 high on 32nd tick", {31'h0, host_irq}, 32'h1);
        wr(2'd0, 32'h1);
        @(negedge clk);
        check("R12 low after ack", {31'h0, host_irq}, 32'h0);

        // R12 clear during wait aborts
        pulse(2'b00, 2'b00, 1'b0, 1'b0, 5'b00001);
        repeat (2) @(negedge clk);
        wr(2'd0, 32'h1);
        @(negedge clk);
        for (int k = 0; k < 40; k++) tick();
        check("R12 aborted wait stays low", {31'h0, host_irq}, 32'h0);

        // R11 urgent bypass with long interval
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFF);
        pulse(2'b01, 2'b00, 1'b0, 1'b0, 5'b00000);
        repeat (10) @(negedge clk);
        check("R9 plain rx waits", {31'h0, host_irq}, 32'h0);
        pulse(2'b00, 2'b00, 1'b0, 1'b1, 5'b00000);
        @(negedge clk);
        check("R11 urgent immediate", {31'h0, host_irq}, 32'h1);
        wr(2'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R12 low after detailed ack", {31'h0, host_irq}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule